// File: doc/BRIEF.md
# PC-Relative Address and Load Unit

This block is one execute stage of a 64-bit RISC core. It takes in one instruction word, the program counter of that instruction and a valid strobe. For the group of instructions that compute addresses or load data relative to the program counter, it decodes the word and returns its result on the next clock edge. The result takes one of three forms: a register writeback, a load request for the memory stage, or a reserved-instruction exception.

Address-generating forms add a scaled immediate to the PC. There are three scalings: a 19-bit immediate scaled by four, a 16-bit immediate moved to the upper half of a 32-bit offset, and that same upper-immediate sum with its low 16 bits cleared afterwards. Load forms produce an address, an access size, an extension flag and a destination, and nothing else. Returning load data, writing the register file and handling pipeline hazards all belong to neighbouring blocks.

A build parameter restricts the unit to a 32-bit core. In that build the two forms that only make sense with 64-bit registers raise the exception.

Top module: `pcrel_unit`

## Requirements
- R1: Only words with bits 31:26 equal to 6'h3B belong to the group. Any other word leaves all outputs at zero in the following cycle.
- R2: Bits 20:19 = 2'b00 write `pc + (sign-extended bits 18:0 << 2)` to the register named by bits 25:21.
- R3: Bits 20:19 = 2'b01 issue a signed word load (`ld_dword`=0, `ld_unsigned`=0). Bits 20:19 = 2'b10 issue an unsigned word load (`ld_unsigned`=1). Both use the address `pc + (sign-extended bits 18:0 << 2)`, and both issue even when the destination is register 0.
- R4: Bits 20:16 = 5'h1E write `pc + (sign-extended bits 15:0 << 16)`.
- R5: Bits 20:16 = 5'h1F write the sum from R4 with bits 15:0 cleared.
- R6: Bits 20:18 = 3'b110 issue a doubleword load (`ld_dword`=1) at `(pc with bits 2:0 cleared) + (sign-extended bits 17:0 << 3)`. Bits 17:16 are part of the immediate.
- R7: The three address-generating forms (R2, R4, R5) with destination register 0 produce no write and no exception.
- R8: Bits 20:16 equal to 5'h1C or 5'h1D inside the group raise `rsv_exc` for one cycle, with no write and no load.
- R9: Every result appears exactly one clock edge after the input is presented and lasts one cycle. At most one of `wb_en`, `ld_req` and `rsv_exc` is high. Data fields read zero whenever their strobe is low. A cycle with `in_valid` low produces nothing.
- R10: All address arithmetic wraps modulo 2^64.
- R11: With `ONLY32`=1, the unsigned word load and the doubleword load raise `rsv_exc` instead of issuing. The signed word load still issues.
- R12: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and PC are valid |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| wb_en | output | 1 | Register write pulse |
| wb_dst | output | 5 | Destination register of the write |
| wb_value | output | 64 | Value to write |
| ld_req | output | 1 | Load request pulse |
| ld_addr | output | 64 | Load address |
| ld_dword | output | 1 | 1 = doubleword access, 0 = word access |
| ld_unsigned | output | 1 | 1 = zero-extend word data, 0 = sign-extend |
| ld_dst | output | 5 | Destination register of the load |
| rsv_exc | output | 1 | Reserved-instruction exception pulse |

## Verification
Each input yields one result, but results of consecutive instructions follow each other with no gap. The risky case is a load pulse still high in the cycle where the next instruction's writeback rises. The stimulus table places loads, address forms and reserved encodings back to back with no idle cycles in between. Each cycle's full output bundle is compared with a model, so a lingering `ld_req` next to a fresh `wb_en` shows up as a mismatch. A second instance built for 32-bit mode receives the same stream, so the exception path and the issue path are checked on identical inputs.

// File: rtl/pcrel_pkg.sv
`timescale 1ns/1ps
package pcrel_pkg;
  localparam logic [5:0] GRP_MAJOR = 6'h3B;
  localparam logic [4:0] SUB_AUPC  = 5'h1E;
  localparam logic [4:0] SUB_ALUPC = 5'h1F;
  localparam logic [2:0] SUB_LDD   = 3'b110;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADDPC = 3'd1,
    OP_LDW   = 3'd2,
    OP_LDWU  = 3'd3,
    OP_AUPC  = 3'd4,
    OP_ALUPC = 3'd5,
    OP_LDD   = 3'd6,
    OP_RSV   = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcrel_decode.sv
`timescale 1ns/1ps
module pcrel_decode
  import pcrel_pkg::*;
#(
  parameter bit ONLY32 = 1'b0,
  parameter int RIDX_W = 5
) (
  input  logic              valid,
  input  logic [31:16]      insn_hi,
  output pc_op_e            op,
  output logic [RIDX_W-1:0] dst
);
  pc_op_e op_raw;
  pc_op_e op_lim;
  logic   grp;

  assign grp = valid && (insn_hi[31:26] == GRP_MAJOR);
  assign dst = insn_hi[25:21];

  // two-level sub-opcode: bits 20:19 first, then bits 20:16
  always_comb begin
    op_raw = OP_NONE;
    if (grp) begin
      unique case (insn_hi[20:19])
        2'b00: op_raw = OP_ADDPC;
        2'b01: op_raw = OP_LDW;
        2'b10: op_raw = OP_LDWU;
        default: begin
          if (insn_hi[20:16] == SUB_AUPC)       op_raw = OP_AUPC;
          else if (insn_hi[20:16] == SUB_ALUPC) op_raw = OP_ALUPC;
          else if (insn_hi[20:18] == SUB_LDD)   op_raw = OP_LDD;
          else                                  op_raw = OP_RSV;
        end
      endcase
    end
  end

  generate
    if (ONLY32) begin : g_narrow
      assign op_lim = (op_raw == OP_LDWU || op_raw == OP_LDD) ? OP_RSV : op_raw;
    end else begin : g_full
      assign op_lim = op_raw;
    end
  endgenerate

  // address forms aimed at register 0 retire silently
  always_comb begin
    op = op_lim;
    if ((op_lim == OP_ADDPC || op_lim == OP_AUPC || op_lim == OP_ALUPC) &&
        dst == '0)
      op = OP_NONE;
  end
endmodule

// File: rtl/pcrel_agen.sv
`timescale 1ns/1ps
module pcrel_agen
  import pcrel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pc_op_e          op,
  input  logic [18:0]     imm,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] addr
);
  localparam int EXT_W = XLEN - 21;
  localparam int EXT_U = XLEN - 32;

  logic [XLEN-1:0] off_w, off_u, off_d, pc_al;
  logic [XLEN-1:0] sum_w, sum_u, sum_d;

  assign off_w = {{EXT_W{imm[18]}}, imm[18:0], 2'b00};
  assign off_u = {{EXT_U{imm[15]}}, imm[15:0], 16'h0000};
  assign off_d = {{EXT_W{imm[17]}}, imm[17:0], 3'b000};
  assign pc_al = {pc[XLEN-1:3], 3'b000};

  assign sum_w = pc + off_w;
  assign sum_u = pc + off_u;
  assign sum_d = pc_al + off_d;

  always_comb begin
    unique case (op)
      OP_ADDPC, OP_LDW, OP_LDWU: addr = sum_w;
      OP_AUPC:                   addr = sum_u;
      OP_ALUPC:                  addr = {sum_u[XLEN-1:16], 16'h0000};
      OP_LDD:                    addr = sum_d;
      default:                   addr = '0;
    endcase
  end
endmodule

// File: rtl/pcrel_issue.sv
`timescale 1ns/1ps
module pcrel_issue
  import pcrel_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_op_e            op,
  input  logic [RIDX_W-1:0] dst,
  input  logic [XLEN-1:0]   addr,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_dst,
  output logic [XLEN-1:0]   wb_value,
  output logic              ld_req,
  output logic [XLEN-1:0]   ld_addr,
  output logic              ld_dword,
  output logic              ld_unsigned,
  output logic [RIDX_W-1:0] ld_dst,
  output logic              rsv_exc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en       <= 1'b0;
      wb_dst      <= '0;
      wb_value    <= '0;
      ld_req      <= 1'b0;
      ld_addr     <= '0;
      ld_dword    <= 1'b0;
      ld_unsigned <= 1'b0;
      ld_dst      <= '0;
      rsv_exc     <= 1'b0;
    end else begin
      wb_en       <= 1'b0;
      wb_dst      <= '0;
      wb_value    <= '0;
      ld_req      <= 1'b0;
      ld_addr     <= '0;
      ld_dword    <= 1'b0;
      ld_unsigned <= 1'b0;
      ld_dst      <= '0;
      rsv_exc     <= 1'b0;
      unique case (op)
        OP_ADDPC, OP_AUPC, OP_ALUPC: begin
          wb_en    <= 1'b1;
          wb_dst   <= dst;
          wb_value <= addr;
        end
        OP_LDW, OP_LDWU, OP_LDD: begin
          ld_req      <= 1'b1;
          ld_addr     <= addr;
          ld_dst      <= dst;
          ld_dword    <= (op == OP_LDD);
          ld_unsigned <= (op == OP_LDWU);
        end
        OP_RSV:  rsv_exc <= 1'b1;
        default: ;
      endcase
    end
  end

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_en, ld_req, rsv_exc}));

  // R7
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_dst != '0));

  // R9
  idle_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_req |-> (ld_addr == '0 && !ld_dword && !ld_unsigned && ld_dst == '0));
endmodule

// File: rtl/pcrel_unit.sv
`timescale 1ns/1ps
module pcrel_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter bit ONLY32 = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_pc,
  output logic            wb_en,
  output logic [4:0]      wb_dst,
  output logic [XLEN-1:0] wb_value,
  output logic            ld_req,
  output logic [XLEN-1:0] ld_addr,
  output logic            ld_dword,
  output logic            ld_unsigned,
  output logic [4:0]      ld_dst,
  output logic            rsv_exc
);
  localparam int RIDX_W = 5;

  pc_op_e            op;
  logic [RIDX_W-1:0] dst;
  logic [XLEN-1:0]   addr;

  pcrel_decode #(.ONLY32(ONLY32), .RIDX_W(RIDX_W)) u_dec (
    .valid   (in_valid),
    .insn_hi (in_insn[31:16]),
    .op      (op),
    .dst     (dst)
  );

  pcrel_agen #(.XLEN(XLEN)) u_agen (
    .op   (op),
    .imm  (in_insn[18:0]),
    .pc   (in_pc),
    .addr (addr)
  );

  pcrel_issue #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_iss (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .dst         (dst),
    .addr        (addr),
    .wb_en       (wb_en),
    .wb_dst      (wb_dst),
    .wb_value    (wb_value),
    .ld_req      (ld_req),
    .ld_addr     (ld_addr),
    .ld_dword    (ld_dword),
    .ld_unsigned (ld_unsigned),
    .ld_dst      (ld_dst),
    .rsv_exc     (rsv_exc)
  );

  // R9
  idle_in_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !(wb_en || ld_req || rsv_exc));

  // R1
  foreign_major_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_insn[31:26]) != GRP_MAJOR) |-> !(wb_en || ld_req || rsv_exc));

  // R3
  word_addr_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !ld_dword) |-> (ld_addr[1:0] == $past(in_pc[1:0])));

  // R5
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_en && $past(in_insn[20:16]) == SUB_ALUPC && $past(in_insn[20:19]) == 2'b11)
      |-> (wb_value[15:0] == 16'h0000));

  generate
    if (ONLY32) begin : g_chk32
      // R11
      narrow_loads_chk: assert property (@(posedge clk) disable iff (rst)
        ld_req |-> (!ld_dword && !ld_unsigned));
    end
  endgenerate
endmodule

// File: tb/pcrel_unit_tb.sv
`timescale 1ns/1ps
module pcrel_unit_tb;
  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] pc;
  } stim_t;

  localparam int NV = 15;
  localparam stim_t VEC [NV] = '{
    {6'h3B, 5'd3,  2'b00, 19'h00010, 64'h0000_0000_0000_1000},  // addpc +
    {6'h3B, 5'd5,  2'b00, 19'h7FFFF, 64'h0000_0000_0000_2000},  // addpc -1
    {6'h3B, 5'd7,  2'b01, 19'h00100, 64'h0000_0000_2000_0000},  // signed word load
    {6'h3B, 5'd8,  2'b10, 19'h40000, 64'h0000_0001_0000_0000},  // unsigned word load
    {6'h3B, 5'd9,  5'h1E, 16'h8000,  64'h1234_5678_9ABC_DEF0},  // upper add
    {6'h3B, 5'd10, 5'h1F, 16'h0001,  64'h0000_0000_FFFF_1234},  // upper add, clear
    {6'h3B, 5'd11, 3'b110, 18'h20001, 64'h0000_0000_0000_1007}, // dword load
    {6'h3B, 5'd4,  5'h1C, 16'h1234,  64'h0000_0000_0000_4000},  // reserved
    {6'h3B, 5'd6,  5'h1D, 16'hFFFF,  64'h0000_0000_0000_4004},  // reserved
    {6'h3B, 5'd0,  2'b00, 19'h00040, 64'h0000_0000_0000_5000},  // addpc r0
    {6'h3B, 5'd0,  5'h1E, 16'h0010,  64'h0000_0000_0000_5004},  // upper add r0
    {6'h3B, 5'd0,  2'b01, 19'h00002, 64'h0000_0000_0000_5008},  // load to r0
    {6'h3B, 5'd12, 5'h1E, 16'h0001,  64'hFFFF_FFFF_FFFF_0000},  // wrap
    {6'h3A, 5'd13, 2'b00, 19'h00010, 64'h0000_0000_0000_6000},  // other major
    {6'h3B, 5'd14, 3'b110, 18'h00001, 64'hFFFF_FFFF_FFFF_FFFF}  // dword wrap
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [63:0] in_pc = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic        wb_en0, ld_req0, ld_dw0, ld_un0, rsv0;
  logic [4:0]  wb_dst0, ld_dst0;
  logic [63:0] wb_val0, ld_addr0;
  logic        wb_en1, ld_req1, ld_dw1, ld_un1, rsv1;
  logic [4:0]  wb_dst1, ld_dst1;
  logic [63:0] wb_val1, ld_addr1;

  pcrel_unit #(.XLEN(64), .ONLY32(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_pc(in_pc),
    .wb_en(wb_en0), .wb_dst(wb_dst0), .wb_value(wb_val0),
    .ld_req(ld_req0), .ld_addr(ld_addr0), .ld_dword(ld_dw0),
    .ld_unsigned(ld_un0), .ld_dst(ld_dst0), .rsv_exc(rsv0));

  pcrel_unit #(.XLEN(64), .ONLY32(1'b1)) u_dut32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_pc(in_pc),
    .wb_en(wb_en1), .wb_dst(wb_dst1), .wb_value(wb_val1),
    .ld_req(ld_req1), .ld_addr(ld_addr1), .ld_dword(ld_dw1),
    .ld_unsigned(ld_un1), .ld_dst(ld_dst1), .rsv_exc(rsv1));

  logic [142:0] obs0, obs1;
  assign obs0 = {wb_en0, wb_dst0, wb_val0, ld_req0, ld_addr0, ld_dw0, ld_un0, ld_dst0, rsv0};
  assign obs1 = {wb_en1, wb_dst1, wb_val1, ld_req1, ld_addr1, ld_dw1, ld_un1, ld_dst1, rsv1};

  function automatic logic [142:0] pack_wb(input logic [4:0] d, input logic [63:0] v);
    return {1'b1, d, v, 1'b0, 64'd0, 1'b0, 1'b0, 5'd0, 1'b0};
  endfunction
  function automatic logic [142:0] pack_ld(input logic [4:0] d, input logic [63:0] a,
                                           input logic dw, input logic un);
    return {1'b0, 5'd0, 64'd0, 1'b1, a, dw, un, d, 1'b0};
  endfunction
  localparam logic [142:0] EXC  = {142'd0, 1'b1};
  localparam logic [142:0] IDLE = '0;

  // reference model written from the requirements
  function automatic logic [142:0] model(input logic [31:0] w, input logic [63:0] pc,
                                         input bit only32, output string req);
    logic [4:0]  d = w[25:21];
    logic [63:0] a_w, a_u, a_d;
    a_w = pc + 64'(longint'($signed(w[18:0])) * 4);
    a_u = pc + 64'(longint'($signed(w[15:0])) * 65536);
    a_d = (pc & ~64'h7) + 64'(longint'($signed(w[17:0])) * 8);
    if (w[31:26] != 6'h3B) begin req = "R1"; return IDLE; end
    if (w[20:19] == 2'b00) begin
      req = (d == 0) ? "R7" : "R2";
      return (d == 0) ? IDLE : pack_wb(d, a_w);
    end
    if (w[20:19] == 2'b01) begin req = "R3"; return pack_ld(d, a_w, 1'b0, 1'b0); end
    if (w[20:19] == 2'b10) begin
      req = only32 ? "R11" : "R3";
      return only32 ? EXC : pack_ld(d, a_w, 1'b0, 1'b1);
    end
    if (w[20:16] == 5'h1E) begin
      req = (d == 0) ? "R7" : ((pc[63:16] == 48'hFFFF_FFFF_FFFF) ? "R10" : "R4");
      return (d == 0) ? IDLE : pack_wb(d, a_u);
    end
    if (w[20:16] == 5'h1F) begin
      req = (d == 0) ? "R7" : "R5";
      return (d == 0) ? IDLE : pack_wb(d, a_u & ~64'hFFFF);
    end
    if (w[20:18] == 3'b110) begin
      req = only32 ? "R11" : ((pc == '1) ? "R10" : "R6");
      return only32 ? EXC : pack_ld(d, a_d, 1'b1, 1'b0);
    end
    req = "R8";
    return EXC;
  endfunction

  task automatic check(input logic [142:0] act, input logic [142:0] exp,
                       input string req, input string who);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, who, act, exp);
    end
  endtask

  initial begin
    string r0, r1;
    logic [142:0] e0, e1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(obs0, IDLE, "R12", "u_dut");
    check(obs1, IDLE, "R12", "u_dut32");
    rst = 1'b0;
    @(negedge clk);

    // table walk, back to back (R9 latency and pulse separation)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_insn  = VEC[i].insn;
      in_pc    = VEC[i].pc;
      e0 = model(VEC[i].insn, VEC[i].pc, 1'b0, r0);
      e1 = model(VEC[i].insn, VEC[i].pc, 1'b1, r1);
      @(negedge clk);
      check(obs0, e0, r0, "u_dut");
      check(obs1, e1, r1, "u_dut32");
    end

    // R9 valid low with a group word present yields nothing
    in_valid = 1'b0;
    in_insn  = VEC[0].insn;
    @(negedge clk);
    check(obs0, IDLE, "R9", "u_dut");

    // R9 result lasts a single cycle
    in_valid = 1'b1;
    in_insn  = VEC[2].insn;
    in_pc    = VEC[2].pc;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(obs0, IDLE, "R9", "u_dut");

    // R12 reset wins over a valid instruction
    in_valid = 1'b1;
    in_insn  = VEC[0].insn;
    in_pc    = VEC[0].pc;
    rst = 1'b1;
    @(negedge clk);
    check(obs0, IDLE, "R12", "u_dut");
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule